// File: doc/BRIEF.md
# Fractional PLL Output Frequency Calculator

This block works out the frequency a fractional-N clock generator is currently producing, given the generator's divider settings and the frequency of its parent clock. A request carries the parent frequency, the feedback divider, the reference divider, two post dividers, a 24-bit fraction, an integer/fractional select, a two-bit mode field and a lock indication. The answer is a 64-bit frequency. It comes back on a valid/ready result channel together with a flag that marks an illegal zero divisor.

The normal, locked path multiplies the parent by the feedback ratio. In fractional operation it adds the fractional contribution, then applies both post dividers and rounds an odd result up to the next even value. All divisions truncate. They run one after another on a single shared restoring divider that produces one quotient bit per clock, so intermediate values stay 96 bits wide. Slow mode, deep slow mode, the reserved mode and a missing lock skip the arithmetic entirely and answer on the next cycle.

The request side follows valid/ready rules. A request is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is high only while the block is idle. The result side applies back-pressure. Once `out_valid` rises, it stays high with `out_freq` and `out_div_err` frozen until a cycle with `out_ready` high. The block accepts its next request only after that.

Top module: `pll_freq_calc`

## Requirements
- R1: A request is accepted on a rising clock edge with `in_valid` and `in_ready` both high. `in_ready` is low from the accepting edge until the result has been taken. Every request field is sampled only at acceptance, so later changes to the fields have no effect on that result.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_freq` and `out_div_err` keep their values. On the edge where both are high, the result is taken. In the next cycle `out_valid` is low and `in_ready` is high.
- R3: With `in_mode` = 1 (normal), `in_locked` = 1 and `in_int_mode` = 1, the result is floor(floor(floor(parent × fbdiv / refdiv) / post1) / post2), using the raw field values as the divisor and multiplier values. It is then subject to R5 and reduced to its low 64 bits. `in_frac` has no effect in this case.
- R4: With `in_int_mode` = 0 and otherwise as in R3, floor(floor(parent × frac / refdiv) / 2^24) is added to floor(parent × fbdiv / refdiv) before the two post divisions.
- R5: If a result computed by R3 or R4 is odd, one is added to it, modulo 2^64. Such a result is therefore always even.
- R6: `in_mode` = 0 (slow) returns the parent frequency unchanged, even if it is odd. `in_mode` = 2 (deep slow) returns 32768. `in_mode` = 3 returns 0. In all three cases the lock input and the divider fields are ignored.
- R7: With `in_mode` = 1 and `in_locked` = 0, the result is 0 and `out_div_err` is 0.
- R8: With `in_mode` = 1 and `in_locked` = 1, if the reference divider or either post divider is zero, the result is 0 and `out_div_err` = 1. `out_div_err` is 0 for every other result.
- R9: Results from R6, R7 and R8 become valid in the cycle after acceptance. An integer computation becomes valid 3 × (96 + 2) = 294 cycles after the accepting edge. A fractional computation becomes valid 4 × (96 + 2) = 392 cycles after it.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_parent | input | 64 | Parent clock frequency |
| in_fbdiv | input | 12 | Feedback divider value |
| in_refdiv | input | 6 | Reference divider value |
| in_post1 | input | 3 | First post divider value |
| in_post2 | input | 3 | Second post divider value |
| in_frac | input | 24 | Fraction of the feedback ratio, in units of 2^-24 |
| in_int_mode | input | 1 | 1 = integer ratio only, 0 = add fractional term |
| in_mode | input | 2 | 0 slow, 1 normal, 2 deep slow, 3 off |
| in_locked | input | 1 | Lock status of the generator |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_freq | output | 64 | Computed frequency |
| out_div_err | output | 1 | Result was forced to zero by a zero divisor |

## Verification
A sequencing fault, such as a skipped or repeated division step or a wrong operand steered into the shared divider, changes either the cycle on which `out_valid` rises or the value it carries. The bench predicts both exactly and compares them on every clock, so a fault is visible on the first cycle it should affect, which is at most 392 cycles after acceptance. A corrupted remainder or quotient register shows up as a wrong truncated value under the mixed divisor patterns. A fault in the result hold logic shows up during the deliberate back-pressure cycles, as a dropped or changed result.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_A,
    ST_DIV_F,
    ST_DIV_P1,
    ST_DIV_P2,
    ST_OUT
  } fpc_state_e;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2,
    MODE_OFF    = 2'd3
  } fpc_mode_e;

endpackage

// File: rtl/fpc_divider.sv
module fpc_divider #(
  parameter int NW = 96,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] den_r;
  logic [DW-1:0] rem_r;
  logic [CW-1:0] cnt_r;
  logic [DW:0]   trial;
  logic          fits;

  // shift the next dividend bit into the partial remainder
  assign trial = {rem_r, quot[NW-1]};
  assign fits  = (trial >= {1'b0, den_r});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
      den_r <= '0;
      rem_r <= '0;
      cnt_r <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        den_r <= den;
        rem_r <= '0;
        quot  <= num;
        cnt_r <= CW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_r <= fits ? DW'(trial - {1'b0, den_r}) : trial[DW-1:0];
        quot  <= {quot[NW-2:0], fits};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && den_r != '0) |-> (rem_r < den_r)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

// File: rtl/fpc_bypass.sv
module fpc_bypass import fpc_pkg::*; #(
  parameter int W_FREQ    = 64,
  parameter int DEEP_FREQ = 32768
) (
  input  logic [1:0]        mode,
  input  logic              locked,
  input  logic [W_FREQ-1:0] parent,
  output logic              hit,
  output logic [W_FREQ-1:0] value
);
  always_comb begin
    hit   = 1'b1;
    value = '0;
    case (mode)
      MODE_SLOW:   value = parent;
      MODE_DEEP:   value = W_FREQ'(DEEP_FREQ);
      MODE_NORMAL: hit   = !locked;
      default:     value = '0;
    endcase
  end

  always_comb begin
    if (mode == MODE_NORMAL && locked)
      AST_NORMAL_NOT_BYPASSED: assert (!hit); // R3
  end

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc import fpc_pkg::*; #(
  parameter int W_FREQ    = 64,
  parameter int W_FB      = 12,
  parameter int W_REF     = 6,
  parameter int W_PD      = 3,
  parameter int W_FRAC    = 24,
  parameter int DEEP_FREQ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W_FREQ-1:0] in_parent,
  input  logic [W_FB-1:0]   in_fbdiv,
  input  logic [W_REF-1:0]  in_refdiv,
  input  logic [W_PD-1:0]   in_post1,
  input  logic [W_PD-1:0]   in_post2,
  input  logic [W_FRAC-1:0] in_frac,
  input  logic              in_int_mode,
  input  logic [1:0]        in_mode,
  input  logic              in_locked,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W_FREQ-1:0] out_freq,
  output logic              out_div_err
);
  localparam int PW = W_FREQ + W_FRAC + 8;

  fpc_state_e        state;
  logic [W_FREQ-1:0] parent_r;
  logic [W_FRAC-1:0] frac_r;
  logic [W_REF-1:0]  ref_r;
  logic [W_PD-1:0]   p1_r;
  logic [W_PD-1:0]   p2_r;
  logic              int_r;
  logic [PW-1:0]     acc_r;
  logic [PW-1:0]     num_r;
  logic [W_REF-1:0]  den_r;
  logic              go_r;
  logic [W_FREQ-1:0] res_r;
  logic              err_r;
  logic              calc_r;

  logic              byp_hit;
  logic [W_FREQ-1:0] byp_val;
  logic              zero_div;
  logic              div_busy;
  logic              div_done;
  logic [PW-1:0]     div_q;

  fpc_bypass #(.W_FREQ(W_FREQ), .DEEP_FREQ(DEEP_FREQ)) u_bypass (
    .mode   (in_mode),
    .locked (in_locked),
    .parent (in_parent),
    .hit    (byp_hit),
    .value  (byp_val)
  );

  fpc_divider #(.NW(PW), .DW(W_REF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_r),
    .num   (num_r),
    .den   (den_r),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_q)
  );

  assign zero_div    = (in_refdiv == '0) || (in_post1 == '0) || (in_post2 == '0);
  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_OUT);
  assign out_freq    = res_r;
  assign out_div_err = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      parent_r <= '0;
      frac_r   <= '0;
      ref_r    <= '0;
      p1_r     <= '0;
      p2_r     <= '0;
      int_r    <= 1'b0;
      acc_r    <= '0;
      num_r    <= '0;
      den_r    <= '0;
      go_r     <= 1'b0;
      res_r    <= '0;
      err_r    <= 1'b0;
      calc_r   <= 1'b0;
    end else begin
      go_r <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            parent_r <= in_parent;
            frac_r   <= in_frac;
            ref_r    <= in_refdiv;
            p1_r     <= in_post1;
            p2_r     <= in_post2;
            int_r    <= in_int_mode;
            if (byp_hit) begin
              res_r  <= byp_val;
              err_r  <= 1'b0;
              calc_r <= 1'b0;
              state  <= ST_OUT;
            end else if (zero_div) begin
              res_r  <= '0;
              err_r  <= 1'b1;
              calc_r <= 1'b0;
              state  <= ST_OUT;
            end else begin
              num_r  <= PW'(in_parent) * PW'(in_fbdiv);
              den_r  <= in_refdiv;
              go_r   <= 1'b1;
              err_r  <= 1'b0;
              calc_r <= 1'b1;
              state  <= ST_DIV_A;
            end
          end
        end
        ST_DIV_A: begin
          if (div_done) begin
            acc_r <= div_q;
            go_r  <= 1'b1;
            if (int_r) begin
              num_r <= div_q;
              den_r <= W_REF'(p1_r);
              state <= ST_DIV_P1;
            end else begin
              num_r <= PW'(parent_r) * PW'(frac_r);
              den_r <= ref_r;
              state <= ST_DIV_F;
            end
          end
        end
        ST_DIV_F: begin
          if (div_done) begin
            num_r <= acc_r + (div_q >> W_FRAC);
            den_r <= W_REF'(p1_r);
            go_r  <= 1'b1;
            state <= ST_DIV_P1;
          end
        end
        ST_DIV_P1: begin
          if (div_done) begin
            num_r <= div_q;
            den_r <= W_REF'(p2_r);
            go_r  <= 1'b1;
            state <= ST_DIV_P2;
          end
        end
        ST_DIV_P2: begin
          if (div_done) begin
            res_r <= W_FREQ'(div_q + PW'(div_q[0]));
            state <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_freq) && $stable(out_div_err))); // R2

  AST_RELEASE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R2

  AST_EVEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && calc_r) |-> !out_freq[0]); // R5

  AST_ERR_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_err) |-> (out_freq == '0)); // R8

  AST_DIVIDER_IDLE_AT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !div_busy); // R9

endmodule

// File: tb/pll_freq_calc_test.sv
module pll_freq_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 96 + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_parent = '0;
  logic [11:0] in_fbdiv = '0;
  logic [5:0]  in_refdiv = '0;
  logic [2:0]  in_post1 = '0;
  logic [2:0]  in_post2 = '0;
  logic [23:0] in_frac = '0;
  logic        in_int_mode = 1'b1;
  logic [1:0]  in_mode = '0;
  logic        in_locked = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_freq;
  logic        out_div_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  pll_freq_calc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_parent(in_parent), .in_fbdiv(in_fbdiv), .in_refdiv(in_refdiv),
    .in_post1(in_post1), .in_post2(in_post2), .in_frac(in_frac),
    .in_int_mode(in_int_mode), .in_mode(in_mode), .in_locked(in_locked),
    .out_valid(out_valid), .out_ready(out_ready), .out_freq(out_freq),
    .out_div_err(out_div_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R9 watchdog: cycles=%0d expected below 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] p, input logic [11:0] fb, input logic [5:0] rd,
                        input logic [2:0] d1, input logic [2:0] d2, input logic [23:0] fr,
                        input logic im, input logic [1:0] md, input logic lk,
                        input int hold, input string req);
    logic [127:0] a;
    logic [127:0] f;
    logic [63:0]  exp_f;
    logic         exp_e;
    int           lat;
    bit           expv;
    exp_e = 1'b0;
    lat   = 0;
    if (md == 2'd0)      exp_f = p;
    else if (md == 2'd2) exp_f = 64'd32768;
    else if (md == 2'd3) exp_f = 64'd0;
    else if (!lk)        exp_f = 64'd0;
    else if (rd == 0 || d1 == 0 || d2 == 0) begin
      exp_f = 64'd0;
      exp_e = 1'b1;
    end else begin
      a = (128'(p) * 128'(fb)) / 128'(rd);
      if (!im) begin
        f = (128'(p) * 128'(fr)) / 128'(rd);
        a = a + (f >> 24);
      end
      a = a / 128'(d1);
      a = a / 128'(d2);
      if (a[0]) a = a + 128'd1;
      exp_f = a[63:0];
      lat = (im ? 3 : 4) * STEP;
    end

    @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready before request", 64'(in_ready), 64'd1);
    in_parent = p; in_fbdiv = fb; in_refdiv = rd; in_post1 = d1; in_post2 = d2;
    in_frac = fr; in_int_mode = im; in_mode = md; in_locked = lk;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // scramble every field after acceptance: none may reach the result (R1)
    in_parent = ~p; in_fbdiv = ~fb; in_refdiv = ~rd; in_post1 = ~d1; in_post2 = ~d2;
    in_frac = ~fr; in_int_mode = ~im; in_mode = ~md; in_locked = ~lk;
    for (int k = 1; k < 100000; k++) begin
      expv = (k - 1 >= lat);
      chk(out_valid === expv, "R9 result timing", 64'(out_valid), 64'(expv));
      chk(in_ready === 1'b0, "R1 busy after accept", 64'(in_ready), 64'd0);
      if (expv) begin
        chk(out_freq === exp_f, req, out_freq, exp_f);
        chk(out_div_err === exp_e, "R8 error flag", 64'(out_div_err), 64'(exp_e));
        if (k - 1 >= lat + hold) begin
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          chk(out_valid === 1'b0, "R2 valid drops after take", 64'(out_valid), 64'd0);
          chk(in_ready === 1'b1, "R2 ready returns after take", 64'(in_ready), 64'd1);
          break;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R10 reset ready", 64'(in_ready), 64'd1);
    chk(out_valid === 1'b0, "R10 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    run_op(64'd24000000, 12'd100, 6'd1, 3'd2, 3'd1, 24'd0, 1'b1, 2'd1, 1'b1, 0, "R3 integer ratio");
    run_op(64'd1000, 12'd7, 6'd3, 3'd2, 3'd3, 24'd0, 1'b1, 2'd1, 1'b1, 2, "R3 truncating divisions");
    run_op(64'd1000, 12'd7, 6'd3, 3'd2, 3'd3, 24'hABCDEF, 1'b1, 2'd1, 1'b1, 0, "R3 fraction ignored");
    run_op(64'd1001, 12'd1, 6'd1, 3'd1, 3'd1, 24'd0, 1'b1, 2'd1, 1'b1, 1, "R5 odd rounded up");
    run_op(64'd24000000, 12'd50, 6'd1, 3'd1, 3'd1, 24'h800000, 1'b0, 2'd1, 1'b1, 0, "R4 half fraction");
    run_op(64'd26000000, 12'd33, 6'd5, 3'd3, 3'd2, 24'h123457, 1'b0, 2'd1, 1'b1, 3, "R4 mixed fraction");
    run_op(64'd12345, 12'd9, 6'd2, 3'd1, 3'd1, 24'd0, 1'b1, 2'd0, 1'b0, 2, "R6 slow passes parent");
    run_op(64'd777, 12'd9, 6'd0, 3'd0, 3'd1, 24'd0, 1'b0, 2'd2, 1'b1, 0, "R6 deep slow constant");
    run_op(64'd777, 12'd9, 6'd2, 3'd1, 3'd1, 24'd0, 1'b1, 2'd3, 1'b1, 0, "R6 off mode zero");
    run_op(64'd24000000, 12'd100, 6'd1, 3'd1, 3'd1, 24'd0, 1'b1, 2'd1, 1'b0, 1, "R7 unlocked zero");
    run_op(64'd24000000, 12'd100, 6'd0, 3'd1, 3'd1, 24'd0, 1'b1, 2'd1, 1'b1, 0, "R8 zero refdiv");
    run_op(64'd24000000, 12'd100, 6'd1, 3'd0, 3'd1, 24'd0, 1'b0, 2'd1, 1'b1, 0, "R8 zero post1");
    run_op(64'd24000000, 12'd100, 6'd1, 3'd1, 3'd0, 24'd0, 1'b1, 2'd1, 1'b1, 2, "R8 zero post2");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 12'hFFF, 6'd1, 3'd1, 3'd1, 24'hFFFFFF, 1'b0, 2'd1, 1'b1, 0, "R5 wide truncation");

    for (int i = 0; i < 12; i++) begin
      logic [63:0] rp;
      logic        rim;
      rp  = {$urandom(), $urandom()} >> ($urandom() % 40);
      rim = 1'($urandom() % 2);
      run_op(rp, 12'($urandom()), 6'(1 + $urandom() % 63), 3'(1 + $urandom() % 7),
             3'(1 + $urandom() % 7), 24'($urandom()), rim, 2'd1, 1'b1,
             int'($urandom() % 3), rim ? "R3 random integer" : "R4 random fractional");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule